// File: doc/BRIEF.md
# Wake and Mode Sequencing Controller

This block keeps track of whether a transceiver-style device is asleep, in standby, or in normal operation. A host changes the mode by writing a configuration word. The configuration word also carries the wake sensitivity, an error-timer disable, an inhibit disable and a soft-reset request. An asynchronous wake pin is synchronized and passed through an edge detector. Its sensitivity can be set to no edge, rising edges, falling edges or both. A detected edge while asleep moves the device to standby and raises a wake-request flag.

A wake out of sleep opens a long error window, four minutes by default, counted in millisecond ticks. The window closes when a host access arrives. If no access arrives before the window ends, the device falls back to sleep. The same window always runs after a power-on reset or a soft reset, whatever the disable setting. The inhibit-style enable output is high in every mode except sleep, unless the inhibit-disable setting is set.

Top module: `wake_mode_seq`

## Requirements
- R1: After reset, curMode is standby (01), wakeReq is 0, inhEn is 1 and windowActive is 1. The wake sensitivity resets to 11, and the error-disable and inhibit-disable settings reset to 0.
- R2: A configuration write (cfgWe) with cfgModeSel 00, 01 or 10 sets curMode to sleep (00), standby (01) or normal (10) on the next clock edge.
- R3: A configuration write with cfgModeSel 11 leaves curMode unchanged. The other fields of the word are still taken.
- R4: The wake sensitivity code selects which edges count: 00 none, 01 rising, 10 falling, 11 both. A counted edge of wakePin while curMode is sleep moves curMode to standby and sets wakeReq. The edge reaches the mode within three clock edges, because of a two-flop synchronizer.
- R5: Wake pin edges seen in standby or normal do not change curMode and do not set wakeReq.
- R6: A wake from sleep starts the error window (windowActive = 1). If WIN_MS msTick pulses arrive without a host access, curMode returns to sleep and windowActive drops. After WIN_MS-1 pulses the device is still in standby.
- R7: A hostAccess pulse, or any configuration write (including one that selects normal mode), closes the window and clears wakeReq.
- R8: With the error-disable setting at 1, a wake from sleep does not start the window, and the device stays in standby indefinitely.
- R9: The window runs after power-on reset and after a soft reset, even if the error-disable setting was 1 before the soft reset.
- R10: A configuration write with cfgDevReset = 1 restores the reset values of R1 and ignores the other fields. The request is not held, so the next write acts normally.
- R11: inhEn is 1 exactly when curMode is not sleep and the inhibit-disable setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| msTick | input | 1 | One-cycle pulse per millisecond of the error window timebase |
| wakePin | input | 1 | Asynchronous wake pin |
| hostAccess | input | 1 | Pulse for a host register read or write |
| cfgWe | input | 1 | Configuration word write strobe |
| cfgWakeSense | input | 2 | Wake edge sensitivity code |
| cfgModeSel | input | 2 | Requested mode code |
| cfgSweDis | input | 1 | 1 stops the window from starting on a wake from sleep |
| cfgInhDis | input | 1 | 1 forces inhEn low |
| cfgDevReset | input | 1 | 1 restores all defaults |
| curMode | output | 2 | Current mode: 00 sleep, 01 standby, 10 normal |
| wakeReq | output | 1 | Wake request flag |
| inhEn | output | 1 | Inhibit-style enable |
| windowActive | output | 1 | Error window running |

## Verification
The bench builds the block with WIN_MS = 8, so the full window expiry fits in a few cycles. Both window boundaries can then be checked exactly: WIN_MS-1 ticks and WIN_MS ticks. All four sensitivity codes are swept against both edge directions, from sleep and from the awake modes. The inhibit output is swept over every mode and disable value, with the expected results worked out arithmetically from the codes.

// File: rtl/wms_pkg.sv
package wms_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_NORMAL  = 2'b10
  } wmsMode_t;

  localparam logic [1:0] SENSE_DEFAULT = 2'b11;
  localparam logic [1:0] MODE_RSVD     = 2'b11;

  typedef struct packed {
    logic winStart;
    logic winCancel;
  } winStrobes_t;
endpackage

// File: rtl/wms_datapath.sv
module wms_datapath
  import wms_pkg::*;
#(
  parameter int WIN_MS = 240000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wakePin,
  input  logic [1:0]  wakeSense,
  input  logic        msTick,
  input  winStrobes_t strobes,
  output logic        wakeEdge,
  output logic        winExpire,
  output logic        winActive
);
  localparam int CW = (WIN_MS > 2) ? $clog2(WIN_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_MS - 1);

  logic syncA, syncB, syncPrev;
  logic [CW-1:0] winCnt;
  logic riseSeen, fallSeen, lastTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= wakePin;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseSeen = syncB & ~syncPrev;
  assign fallSeen = ~syncB & syncPrev;
  assign wakeEdge = (wakeSense[0] & riseSeen) | (wakeSense[1] & fallSeen);

  assign lastTick  = winActive && msTick && (winCnt == LAST);
  assign winExpire = lastTick && !strobes.winStart && !strobes.winCancel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winActive <= 1'b1;
      winCnt    <= '0;
    end else if (strobes.winStart) begin
      winActive <= 1'b1;
      winCnt    <= '0;
    end else if (strobes.winCancel || lastTick) begin
      winActive <= 1'b0;
      winCnt    <= '0;
    end else if (winActive && msTick) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= LAST); // R6
  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.winCancel && !strobes.winStart |=> !winActive); // R7
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.winStart |=> winActive && winCnt == '0); // R9
endmodule

// File: rtl/wms_control.sv
module wms_control
  import wms_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostAccess,
  input  logic        cfgWe,
  input  logic [1:0]  cfgWakeSense,
  input  logic [1:0]  cfgModeSel,
  input  logic        cfgSweDis,
  input  logic        cfgInhDis,
  input  logic        cfgDevReset,
  input  logic        wakeEdge,
  input  logic        winExpire,
  output winStrobes_t strobes,
  output wmsMode_t    mode,
  output logic [1:0]  wakeSense,
  output logic        inhDis,
  output logic        wakeReq
);
  logic softRst, cfgWrite, wakeFire, sweDis;

  assign softRst  = cfgWe && cfgDevReset;
  assign cfgWrite = cfgWe && !cfgDevReset;
  assign wakeFire = (mode == MODE_SLEEP) && wakeEdge && !cfgWe;

  assign strobes.winStart  = softRst || (wakeFire && !sweDis);
  assign strobes.winCancel = hostAccess || cfgWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_STANDBY;
      wakeSense <= SENSE_DEFAULT;
      sweDis    <= 1'b0;
      inhDis    <= 1'b0;
      wakeReq   <= 1'b0;
    end else if (softRst) begin
      mode      <= MODE_STANDBY;
      wakeSense <= SENSE_DEFAULT;
      sweDis    <= 1'b0;
      inhDis    <= 1'b0;
      wakeReq   <= 1'b0;
    end else begin
      if (cfgWrite) begin
        wakeSense <= cfgWakeSense;
        sweDis    <= cfgSweDis;
        inhDis    <= cfgInhDis;
        if (cfgModeSel != MODE_RSVD) mode <= wmsMode_t'(cfgModeSel);
      end else if (winExpire) begin
        mode <= MODE_SLEEP;
      end else if (wakeFire) begin
        mode <= MODE_STANDBY;
      end
      if (wakeFire)                 wakeReq <= 1'b1;
      else if (hostAccess || cfgWe) wakeReq <= 1'b0;
    end
  end

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && cfgModeSel == MODE_RSVD |=> mode == $past(mode)); // R3
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(mode) == MODE_SLEEP); // R5
  AST_EXPIRE_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    winExpire |=> mode == MODE_SLEEP); // R6
  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> mode == MODE_STANDBY && wakeSense == SENSE_DEFAULT && !inhDis && !wakeReq); // R10
endmodule

// File: rtl/wake_mode_seq.sv
module wake_mode_seq
  import wms_pkg::*;
#(
  parameter int WIN_MS = 240000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       wakePin,
  input  logic       hostAccess,
  input  logic       cfgWe,
  input  logic [1:0] cfgWakeSense,
  input  logic [1:0] cfgModeSel,
  input  logic       cfgSweDis,
  input  logic       cfgInhDis,
  input  logic       cfgDevReset,
  output logic [1:0] curMode,
  output logic       wakeReq,
  output logic       inhEn,
  output logic       windowActive
);
  winStrobes_t strobes;
  wmsMode_t    mode;
  logic [1:0]  wakeSense;
  logic        inhDis, wakeEdge, winExpire;

  wms_control u_control (
    .clk(clk), .rstN(rstN), .hostAccess(hostAccess), .cfgWe(cfgWe),
    .cfgWakeSense(cfgWakeSense), .cfgModeSel(cfgModeSel), .cfgSweDis(cfgSweDis),
    .cfgInhDis(cfgInhDis), .cfgDevReset(cfgDevReset), .wakeEdge(wakeEdge),
    .winExpire(winExpire), .strobes(strobes), .mode(mode), .wakeSense(wakeSense),
    .inhDis(inhDis), .wakeReq(wakeReq)
  );

  wms_datapath #(.WIN_MS(WIN_MS)) u_datapath (
    .clk(clk), .rstN(rstN), .wakePin(wakePin), .wakeSense(wakeSense),
    .msTick(msTick), .strobes(strobes), .wakeEdge(wakeEdge),
    .winExpire(winExpire), .winActive(windowActive)
  );

  assign curMode = mode;
  assign inhEn   = (mode != MODE_SLEEP) && !inhDis;

  AST_INH_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    curMode == 2'b00 |-> !inhEn); // R11
endmodule

// File: tb/test_wake_mode_seq.sv
module test_wake_mode_seq;
  localparam int WIN = 8;
  logic clk = 1'b0, rstN = 1'b0, msTick = 1'b0, wakePin = 1'b0, hostAccess = 1'b0;
  logic cfgWe = 1'b0, cfgSweDis = 1'b0, cfgInhDis = 1'b0, cfgDevReset = 1'b0;
  logic [1:0] cfgWakeSense = 2'b11, cfgModeSel = 2'b01;
  logic [1:0] curMode;
  logic wakeReq, inhEn, windowActive;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_mode_seq #(.WIN_MS(WIN)) i_wake_mode_seq (
    .clk(clk), .rstN(rstN), .msTick(msTick), .wakePin(wakePin),
    .hostAccess(hostAccess), .cfgWe(cfgWe), .cfgWakeSense(cfgWakeSense),
    .cfgModeSel(cfgModeSel), .cfgSweDis(cfgSweDis), .cfgInhDis(cfgInhDis),
    .cfgDevReset(cfgDevReset), .curMode(curMode), .wakeReq(wakeReq),
    .inhEn(inhEn), .windowActive(windowActive)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sense, input logic [1:0] md,
                    input logic swe, input logic inh, input logic rst);
    cfgWakeSense = sense; cfgModeSel = md; cfgSweDis = swe;
    cfgInhDis = inh; cfgDevReset = rst; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; cfgDevReset = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; @(negedge clk); msTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic access();
    hostAccess = 1'b1; @(negedge clk); hostAccess = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 mode", curMode, 1);
    check("R1 wakeReq", wakeReq, 0);
    check("R1 inhEn", inhEn, 1);
    check("R1 window", windowActive, 1);
    // R9 power-up window expires to sleep
    ticks(WIN - 1);
    check("R9 still standby", curMode, 1);
    ticks(1);
    check("R9 sleep after window", curMode, 0);
    check("R9 window off", windowActive, 0);

    // R4 sweep sense codes against both edge directions, from sleep
    for (int st = 0; st < 2; st++) begin
      for (int s = 0; s < 4; s++) begin
        automatic int fire = (st == 0) ? (s & 1) : ((s >> 1) & 1);
        wakePin = st[0];
        cyc(4);
        wr(s[1:0], 2'b00, 1'b0, 1'b0, 1'b0);
        check("R2 sleep write", curMode, 0);
        wakePin = ~st[0];
        cyc(4);
        check($sformatf("R4 mode sense=%0d start=%0d", s, st), curMode, fire);
        check($sformatf("R4 wakeReq sense=%0d start=%0d", s, st), wakeReq, fire);
        check("R6 window starts on wake", windowActive, fire);
        if (fire != 0) begin
          access();
          check("R7 access closes window", windowActive, 0);
          check("R7 access clears wakeReq", wakeReq, 0);
          ticks(WIN + 2);
          check("R7 no return to sleep", curMode, 1);
        end
      end
    end

    // R5 edges while awake are ignored
    for (int m = 1; m < 3; m++) begin
      wr(2'b11, m[1:0], 1'b0, 1'b0, 1'b0);
      check("R2 mode write", curMode, m);
      wakePin = ~wakePin; cyc(4);
      wakePin = ~wakePin; cyc(4);
      check("R5 mode kept", curMode, m);
      check("R5 no wakeReq", wakeReq, 0);
    end

    // R3 reserved code keeps mode, other fields still taken
    wr(2'b11, 2'b11, 1'b0, 1'b1, 1'b0);
    check("R3 reserved keeps normal", curMode, 2);
    check("R3 inhibit field taken", inhEn, 0);

    // R6 window expiry after wake
    wr(2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
    wakePin = ~wakePin; cyc(4);
    check("R6 woke", curMode, 1);
    ticks(WIN - 1);
    check("R6 standby at WIN-1", curMode, 1);
    check("R6 window running", windowActive, 1);
    ticks(1);
    check("R6 sleep at WIN", curMode, 0);
    check("R6 window closed", windowActive, 0);

    // R7 normal-mode write closes window
    wakePin = ~wakePin; cyc(4);
    check("R7 woke", wakeReq, 1);
    wr(2'b11, 2'b10, 1'b0, 1'b0, 1'b0);
    check("R7 normal write closes", windowActive, 0);
    check("R7 normal write clears flag", wakeReq, 0);
    ticks(WIN + 1);
    check("R7 stays normal", curMode, 2);

    // R8 error-disable
    wr(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    wakePin = ~wakePin; cyc(4);
    check("R8 woke", curMode, 1);
    check("R8 no window", windowActive, 0);
    ticks(WIN + 2);
    check("R8 stays standby", curMode, 1);

    // R10/R9 soft reset with disable set beforehand
    wr(2'b00, 2'b10, 1'b1, 1'b1, 1'b0);
    wr(2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    check("R10 mode default", curMode, 1);
    check("R10 inhibit default", inhEn, 1);
    check("R9 window after soft reset", windowActive, 1);
    ticks(WIN);
    check("R9 soft reset window expires", curMode, 0);
    wakePin = ~wakePin; cyc(4);
    check("R10 sense default both edges", curMode, 1);
    wr(2'b11, 2'b10, 1'b0, 1'b0, 1'b0);
    check("R10 next write acts normally", curMode, 2);

    // R11 inhibit sweep
    for (int m = 0; m < 3; m++) begin
      for (int h = 0; h < 2; h++) begin
        wr(2'b00, m[1:0], 1'b0, h[0], 1'b0);
        check($sformatf("R11 mode=%0d inh=%0d", m, h), inhEn, (m != 0 && h == 0) ? 1 : 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule